// File: doc/BRIEF.md
# SRAM Sleep-State Sequencer

This block sequences a power-saving sleep state for a synchronous SRAM. A sleep request arrives on an input with no timing relation to the clock. It passes through a flop synchroniser. The block then steps through a fixed two-cycle entry phase, a sleep phase, a fixed two-cycle exit phase and a recovery window whose length is a parameter. Storage is not touched, so the array keeps its contents across the whole sequence.

From the start of entry until the recovery window ends, the block raises an inhibit output. The surrounding access logic uses it to drop any access still in flight and to refuse new ones. The block also watches the combined chip-select and the two address strobes. It raises a sticky violation flag in three cases: the part was still selected when entry began, a strobe or select arrived while asleep, or a strobe or select arrived before recovery ended.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `sleep_active`, `access_block` and `viol` are all 0. Reset is synchronous and active high.
- R2: The request goes through a synchroniser of `SYNC_STAGES` flops (default 2). With the default, a rising `sleep_req_async` set up before rising edge k raises `access_block` after edge k+2 and not earlier.
- R3: Entry lasts exactly two cycles. `sleep_active` rises two clock edges after `access_block` rises.
- R4: Exit lasts exactly two cycles. With the default synchroniser, a falling request set up before edge k lowers `sleep_active` after edge k+4.
- R5: After `sleep_active` falls, `access_block` stays high for exactly `RECOV_CYC` more cycles and then drops to 0.
- R6: `access_block` is high whenever `sleep_active` is high, and also during entry, exit and recovery. Accesses in flight at entry are therefore inhibited.
- R7: Any of `chip_sel`, `strb_proc` or `strb_ctrl` sampled high while `access_block` is high sets `viol` after that edge. Once set, `viol` stays high until reset.
- R8: Select or strobe activity sampled on the edge where entry starts, which is the edge that raises `access_block`, sets `viol`. The part must be deselected before entry.
- R9: Select and strobe activity while the block is awake and no request has been synchronised has no effect: `viol`, `access_block` and `sleep_active` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req_async | input | 1 | Sleep request, asynchronous to `clk`, active high |
| chip_sel | input | 1 | Combined chip-enable, active high when the part is selected |
| strb_proc | input | 1 | Processor-side address strobe, active high |
| strb_ctrl | input | 1 | Controller-side address strobe, active high |
| sleep_active | output | 1 | High while asleep, including the two exit cycles |
| access_block | output | 1 | High from the start of entry to the end of recovery |
| viol | output | 1 | Sticky protocol-violation flag |

## Verification
The request is toggled with the select and strobe inputs held idle. This pins the exact edge of each phase change and separates a wrong synchroniser depth from a wrong entry length or a wrong exit length. Strobes are then pulsed in separate runs in four places: while awake, on the entry edge itself, during sleep and during recovery. Comparing the runs shows whether the guard tracks the right window: the awake pulse and the pulse one edge before entry must leave `viol` clear, and the others must set it. A reset after each violation shows that the flag is sticky and that reset alone clears it.

// File: rtl/sram_sleep_pkg.sv
package sram_sleep_pkg;

    localparam int unsigned PHASE_CYC = 2;

    typedef enum logic [2:0] {
        ST_AWAKE,
        ST_ENTER,
        ST_ASLEEP,
        ST_EXIT,
        ST_RECOVER
    } slp_state_e;

    typedef struct packed {
        logic sleeping;
        logic blocking;
    } slp_status_t;

    function automatic logic any_active(input logic cs, input logic sp, input logic sc);
        return cs | sp | sc;
    endfunction

    function automatic slp_status_t decode_status(input slp_state_e s);
        slp_status_t r;
        r.sleeping = (s == ST_ASLEEP) || (s == ST_EXIT);
        r.blocking = (s != ST_AWAKE);
        return r;
    endfunction

endpackage

// File: rtl/sram_sleep_sync.sv
module sram_sleep_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sram_sleep_seq.sv
module sram_sleep_seq
    import sram_sleep_pkg::*;
#(
    parameter int unsigned RECOV_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_s,
    output slp_state_e state
);
    localparam int unsigned LIMIT   = (RECOV_CYC > PHASE_CYC) ? RECOV_CYC : PHASE_CYC;
    localparam int unsigned CW      = $clog2(LIMIT) + 1;
    localparam logic [CW-1:0] PH_LAST = CW'(PHASE_CYC - 1);
    localparam logic [CW-1:0] RC_LAST = CW'(RECOV_CYC - 1);

    slp_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_AWAKE: begin
                if (req_s) begin
                    state_d = ST_ENTER;
                    cnt_d   = '0;
                end
            end
            ST_ENTER: begin
                if (cnt_q == PH_LAST) begin
                    state_d = ST_ASLEEP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ASLEEP: begin
                if (!req_s) begin
                    state_d = ST_EXIT;
                    cnt_d   = '0;
                end
            end
            ST_EXIT: begin
                if (cnt_q == PH_LAST) begin
                    state_d = ST_RECOVER;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt_q == RC_LAST) begin
                    state_d = ST_AWAKE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_AWAKE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_AWAKE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/sram_sleep_guard.sv
module sram_sleep_guard
    import sram_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slp_state_e state,
    input  logic       req_s,
    input  logic       activity,
    output logic       viol
);
    logic viol_q;
    logic window;

    // Guarded window: any non-awake state, plus the awake cycle in which entry starts.
    assign window = (state != ST_AWAKE) || req_s;

    always_ff @(posedge clk) begin
        if (rst)                    viol_q <= 1'b0;
        else if (activity && window) viol_q <= 1'b1;
    end

    assign viol = viol_q;
endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
    import sram_sleep_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RECOV_CYC   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req_async,
    input  logic chip_sel,
    input  logic strb_proc,
    input  logic strb_ctrl,
    output logic sleep_active,
    output logic access_block,
    output logic viol
);
    logic        req_s;
    logic        activity;
    slp_state_e  state;
    slp_status_t status;

    sram_sleep_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (sleep_req_async),
        .sync_out (req_s)
    );

    sram_sleep_seq #(.RECOV_CYC(RECOV_CYC)) seq_i (
        .clk   (clk),
        .rst   (rst),
        .req_s (req_s),
        .state (state)
    );

    assign activity = any_active(chip_sel, strb_proc, strb_ctrl);

    sram_sleep_guard guard_i (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .req_s    (req_s),
        .activity (activity),
        .viol     (viol)
    );

    assign status       = decode_status(state);
    assign sleep_active = status.sleeping;
    assign access_block = status.blocking;
endmodule

// File: rtl/sram_sleep_chk.sv
module sram_sleep_chk (
    input logic clk,
    input logic rst,
    input logic chip_sel,
    input logic strb_proc,
    input logic strb_ctrl,
    input logic sleep_active,
    input logic access_block,
    input logic viol
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!sleep_active && !access_block && !viol));

    assert_entry_two_cycles_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_active) |-> $past(access_block, 2));

    assert_entry_not_early_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(access_block) |=> (access_block && !sleep_active));

    assert_recovery_follows_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_active) |-> access_block);

    assert_sleep_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        sleep_active |-> access_block);

    assert_activity_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (access_block && (chip_sel || strb_proc || strb_ctrl)) |=> viol);

    assert_viol_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol);
endmodule

bind sram_sleep_ctrl sram_sleep_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .chip_sel     (chip_sel),
    .strb_proc    (strb_proc),
    .strb_ctrl    (strb_ctrl),
    .sleep_active (sleep_active),
    .access_block (access_block),
    .viol         (viol)
);

// File: tb/sram_sleep_ctrl_tb_top.sv
module sram_sleep_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RECOV      = 4;
    localparam int WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst, req, cs, sp, sc;
    logic sleep_active, access_block, viol;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_sleep_ctrl #(.SYNC_STAGES(2), .RECOV_CYC(RECOV)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .sleep_req_async (req),
        .chip_sel        (cs),
        .strb_proc       (sp),
        .strb_ctrl       (sc),
        .sleep_active    (sleep_active),
        .access_block    (access_block),
        .viol            (viol)
    );

    typedef struct {
        int    at;
        logic  sa;
        logic  ab;
        logic  v;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc   = 0;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each expected item at the negedge of its target cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (e.at != cyc || sleep_active !== e.sa || access_block !== e.ab || viol !== e.v) begin
                bad++;
                $display("FAIL %s cyc=%0d actual sa/ab/v=%b%b%b expected %b%b%b",
                         e.req, cyc, sleep_active, access_block, viol, e.sa, e.ab, e.v);
            end
        end
    end

    task automatic expect_at(input int dly, input logic sa, input logic ab,
                             input logic v, input string r);
        exp_t e;
        e.at = cyc + dly; e.sa = sa; e.ab = ab; e.v = v; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        expect_at(0, 1'b0, 1'b0, 1'b0, "R1");
        rst = 1'b0;
        step(1);
        expect_at(0, 1'b0, 1'b0, 1'b0, "R1");
        step(1);
    endtask

    // Raises the request now and checks the entry timeline (R2, R3, R6).
    task automatic enter_sleep(input logic v);
        req = 1'b1;
        expect_at(2, 1'b0, 1'b0, v, "R2");
        expect_at(3, 1'b0, 1'b1, v, "R2");
        expect_at(4, 1'b0, 1'b1, v, "R3");
        expect_at(5, 1'b1, 1'b1, v, "R3");
        step(6);
    endtask

    // Drops the request now and checks exit and recovery (R4, R5).
    task automatic exit_sleep(input logic v);
        req = 1'b0;
        expect_at(4, 1'b1, 1'b1, v, "R4");
        expect_at(5, 1'b0, 1'b1, v, "R4");
        expect_at(5 + RECOV - 1, 1'b0, 1'b1, v, "R5");
        expect_at(5 + RECOV, 1'b0, 1'b0, v, "R5");
        step(6 + RECOV);
    endtask

    initial begin
        req = 1'b0; cs = 1'b0; sp = 1'b0; sc = 1'b0; rst = 1'b1;
        step(1);
        do_reset();

        // R9: activity while awake with no request is ignored.
        cs = 1'b1; sp = 1'b1;
        step(1);
        sc = 1'b1;
        step(1);
        cs = 1'b0; sp = 1'b0; sc = 1'b0;
        expect_at(0, 1'b0, 1'b0, 1'b0, "R9");
        step(2);

        // Clean cycle through sleep.
        enter_sleep(1'b0);
        step(3);
        expect_at(0, 1'b1, 1'b1, 1'b0, "R6");
        exit_sleep(1'b0);

        // R7: strobe while asleep sets a sticky flag.
        enter_sleep(1'b0);
        sp = 1'b1;
        step(1);
        sp = 1'b0;
        expect_at(0, 1'b1, 1'b1, 1'b1, "R7");
        step(2);
        exit_sleep(1'b1);
        expect_at(0, 1'b0, 1'b0, 1'b1, "R7");
        step(1);
        do_reset();

        // R8: select held on the edge where entry starts.
        req = 1'b1;
        step(1);
        cs = 1'b1;          // sampled on the edge before entry: no effect
        step(1);
        expect_at(0, 1'b0, 1'b0, 1'b0, "R8");
        step(1);            // sampled on the entry edge
        cs = 1'b0;
        expect_at(0, 1'b0, 1'b1, 1'b1, "R8");
        step(4);
        expect_at(0, 1'b1, 1'b1, 1'b1, "R8");
        step(1);
        exit_sleep(1'b1);
        do_reset();

        // R5/R7: controller strobe during recovery.
        enter_sleep(1'b0);
        req = 1'b0;
        step(6);            // now in recovery
        expect_at(0, 1'b0, 1'b1, 1'b0, "R5");
        sc = 1'b1;
        step(1);
        sc = 1'b0;
        expect_at(0, 1'b0, 1'b1, 1'b1, "R7");
        step(RECOV + 2);
        expect_at(0, 1'b0, 1'b0, 1'b1, "R7");
        step(1);
        do_reset();

        step(2);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        #1;
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule